// File: doc/BRIEF.md
# Branch Trace Capture Filter

This block sits beside a retirement pipeline and looks at one retired-branch report per cycle. A report says whether the branch was taken, whether its target and its taken/not-taken path were mispredicted, which kind of branch it was, and the privilege level it ran at. It also carries the branch address, the target address and a few prediction-detail bits. A held configuration word sets up the filter. A report that passes every filter while tracing is enabled is stored as one record in a small circular buffer. In the same cycle, a one-cycle capture pulse is raised so that an outside event counter can count captures.

The configuration word has four two-bit selectors: taken, target prediction, path prediction and branch kind. It also has a four-bit privilege mask, a fallback mask that is used when the privilege mask is zero, a payload-select bit, and a kind-bypass bit. The payload-select bit chooses whether a record keeps the target address or the prediction detail. Reset loads a configuration that accepts every branch, so setting the enable input alone starts tracing. Software reads the buffer back by slot index and watches the write pointer and the wrap flag.

Top module: `brtrace_filter`

## Requirements
- R1: After reset the write pointer is 0, the full flag is 0 and capture is low. The reset configuration captures any valid branch of any kind, at any privilege level, when trace_en is high.
- R2: The taken selector is cfg_wdata[1:0]. 0 rejects every branch, 1 keeps only not-taken branches, 2 keeps only taken branches, and 3 keeps both.
- R3: The target selector is cfg_wdata[3:2]. 0 rejects every branch, 1 keeps only branches with a mispredicted target, 2 keeps only branches with a correct target, and 3 keeps both.
- R4: The path selector is cfg_wdata[5:4]. 0 rejects every branch, 1 keeps only branches with a mispredicted direction, 2 keeps only branches with a correct direction, and 3 keeps both.
- R5: The kind selector is cfg_wdata[7:6], compared against br_kind. The br_kind codes are 0 other, 1 IP-relative, 2 return and 3 indirect non-return. Selector 0 rejects every branch. Selector values 1 to 3 keep only branches whose br_kind equals the selector.
- R6: The kind-bypass bit is cfg_wdata[17]. When it is 1, the kind selector is not applied. Reset sets this bit to 1.
- R7: The privilege mask is cfg_wdata[11:8], and bit n allows capture at privilege level n. When the mask is zero, the fallback mask cfg_wdata[16:13] is used in its place. The fallback mask resets to 4'hF.
- R8: A record holds br_src and a payload. When cfg_wdata[12] was 1, the payload is br_detail zero-extended and rd_is_detail is 1. Otherwise the payload is br_target and rd_is_detail is 0.
- R9: Nothing is captured unless both trace_en and br_valid are high.
- R10: capture_o is high in exactly the cycle of an accepted report. The record is written into slot wr_ptr_o at the end of that cycle, and the pointer then advances by one.
- R11: The write pointer wraps from DEPTH-1 (7 by default) to 0. full_o sets on that wrap and then stays set until reset.
- R12: A configuration write takes effect from the next cycle on. A report presented in the same cycle as the write is filtered with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Master capture enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 18 | Configuration word |
| br_valid | input | 1 | Branch report valid |
| br_taken | input | 1 | Branch was taken |
| br_tgt_mis | input | 1 | Target was mispredicted |
| br_path_mis | input | 1 | Direction was mispredicted |
| br_kind | input | 2 | Branch kind code |
| br_priv | input | 2 | Privilege level of the branch |
| br_src | input | ADDR_W | Branch address |
| br_target | input | ADDR_W | Target address |
| br_detail | input | DETAIL_W | Prediction detail bits |
| capture_o | output | 1 | One-cycle capture pulse |
| wr_ptr_o | output | PTR_W | Next slot to be written |
| full_o | output | 1 | Buffer has wrapped at least once |
| rd_idx | input | PTR_W | Read slot index |
| rd_src | output | ADDR_W | Branch address stored in the slot |
| rd_payload | output | ADDR_W | Target or detail stored in the slot |
| rd_is_detail | output | 1 | Slot payload holds detail |

## Verification
The bench drives a branch in the same cycle as a configuration write. A design that applied the new word at once would drop or add that capture. Selector value 0 must reject every branch, and a design that decodes it as "any" would capture branches it should refuse. A privilege mask of zero must fall back to the separate mask rather than block all levels or open all levels. The bench also runs long enough to wrap the buffer several times, which exposes a pointer that fails to return to zero, a full flag that is late or not sticky, and records that carry the wrong payload after the payload select changes.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

   // Branch kind codes carried on br_kind
   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_IPREL = 2'd1,
      KIND_RET   = 2'd2,
      KIND_INDIR = 2'd3
   } brt_kind_e;

   // Configuration word layout, msb first
   typedef struct packed {
      logic       kind_any;    // [17]
      logic [3:0] dflt_plm;    // [16:13]
      logic       detail_sel;  // [12]
      logic [3:0] plm;         // [11:8]
      logic [1:0] kind_sel;    // [7:6]
      logic [1:0] path_sel;    // [5:4]
      logic [1:0] tgt_sel;     // [3:2]
      logic [1:0] taken_sel;   // [1:0]
   } brt_cfg_t;

   localparam int CFG_W = $bits(brt_cfg_t);

   localparam brt_cfg_t CFG_RESET = '{
      kind_any:   1'b1,
      dflt_plm:   4'hF,
      detail_sel: 1'b0,
      plm:        4'h0,
      kind_sel:   2'd3,
      path_sel:   2'd3,
      tgt_sel:    2'd3,
      taken_sel:  2'd3
   };

   // bit0 admits the "negative" case, bit1 the "positive" case
   function automatic logic sel_admits(input logic [1:0] sel, input logic positive);
      return positive ? sel[1] : sel[0];
   endfunction

endpackage

// File: rtl/brtrace_cfg.sv
module brtrace_cfg
   import brtrace_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output brt_cfg_t         cfg
);

   brt_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   cfg_q <= CFG_RESET;
      else if (we)  cfg_q <= brt_cfg_t'(wdata);
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/brtrace_match.sv
module brtrace_match
   import brtrace_pkg::*;
#(
   parameter int NUM_BIN = 3
)(
   input  brt_cfg_t   cfg,
   input  logic       enable,
   input  logic       valid,
   input  logic       taken,
   input  logic       tgt_mis,
   input  logic       path_mis,
   input  logic [1:0] kind,
   input  logic [1:0] priv,
   output logic       hit
);

   logic [NUM_BIN-1:0]   positive;
   logic [1:0]           sel_arr [NUM_BIN];
   logic [NUM_BIN-1:0]   bin_ok;
   logic                 kind_ok;
   logic [3:0]           eff_plm;
   logic                 priv_ok;

   // Positive sense: taken, target correct, path correct
   assign positive   = {~path_mis, ~tgt_mis, taken};
   assign sel_arr[0] = cfg.taken_sel;
   assign sel_arr[1] = cfg.tgt_sel;
   assign sel_arr[2] = cfg.path_sel;

   if (NUM_BIN != 3) begin : g_bad_bin
      $error("brtrace_match: NUM_BIN must be 3");
   end

   for (genvar i = 0; i < NUM_BIN; i++) begin : g_bin
      assign bin_ok[i] = sel_admits(sel_arr[i], positive[i]);
   end

   always_comb begin
      if (cfg.kind_any)             kind_ok = 1'b1;
      else if (cfg.kind_sel == 2'd0) kind_ok = 1'b0;
      else                           kind_ok = (kind == cfg.kind_sel);
   end

   assign eff_plm = (cfg.plm == 4'h0) ? cfg.dflt_plm : cfg.plm;
   assign priv_ok = eff_plm[priv];

   assign hit = enable & valid & (&bin_ok) & kind_ok & priv_ok;

endmodule

// File: rtl/brtrace_ring.sv
module brtrace_ring #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_src,
   input  logic [DATA_W-1:0] wr_payload,
   input  logic              wr_is_detail,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_src,
   output logic [DATA_W-1:0] rd_payload,
   output logic              rd_is_detail,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic              full
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0]  ptr_q;
   logic              full_q;
   logic [DATA_W-1:0] src_mem [DEPTH];
   logic [DATA_W-1:0] pay_mem [DEPTH];
   logic [DEPTH-1:0]  det_mem;
   logic              at_last;

   if (DEPTH < 2) begin : g_bad_depth
      $error("brtrace_ring: DEPTH must be at least 2");
   end

   assign at_last = (ptr_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         full_q <= 1'b0;
      end else if (wr_en) begin
         ptr_q  <= at_last ? '0 : ptr_q + 1'b1;
         if (at_last) full_q <= 1'b1;
      end
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_mem[s] <= '0;
            pay_mem[s] <= '0;
            det_mem[s] <= 1'b0;
         end else if (wr_en && ptr_q == PTR_W'(s)) begin
            src_mem[s] <= wr_src;
            pay_mem[s] <= wr_payload;
            det_mem[s] <= wr_is_detail;
         end
      end
   end

   always_comb begin
      rd_src       = '0;
      rd_payload   = '0;
      rd_is_detail = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (rd_idx == PTR_W'(k)) begin
            rd_src       = src_mem[k];
            rd_payload   = pay_mem[k];
            rd_is_detail = det_mem[k];
         end
      end
   end

   assign wr_ptr = ptr_q;
   assign full   = full_q;

endmodule

// File: rtl/brtrace_filter.sv
module brtrace_filter
   import brtrace_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int ADDR_W   = 32,
   parameter int DETAIL_W = 8,
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trace_en,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic                br_valid,
   input  logic                br_taken,
   input  logic                br_tgt_mis,
   input  logic                br_path_mis,
   input  logic [1:0]          br_kind,
   input  logic [1:0]          br_priv,
   input  logic [ADDR_W-1:0]   br_src,
   input  logic [ADDR_W-1:0]   br_target,
   input  logic [DETAIL_W-1:0] br_detail,
   output logic                capture_o,
   output logic [PTR_W-1:0]    wr_ptr_o,
   output logic                full_o,
   input  logic [PTR_W-1:0]    rd_idx,
   output logic [ADDR_W-1:0]   rd_src,
   output logic [ADDR_W-1:0]   rd_payload,
   output logic                rd_is_detail
);

   brt_cfg_t            cfg_q;
   logic                hit;
   logic [ADDR_W-1:0]   detail_ext;
   logic [ADDR_W-1:0]   payload;

   if (DETAIL_W > ADDR_W || DETAIL_W < 1) begin : g_bad_detail
      $error("brtrace_filter: DETAIL_W must be 1..ADDR_W");
   end

   brtrace_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg_q)
   );

   brtrace_match #(.NUM_BIN(3)) u_match (
      .cfg      (cfg_q),
      .enable   (trace_en),
      .valid    (br_valid),
      .taken    (br_taken),
      .tgt_mis  (br_tgt_mis),
      .path_mis (br_path_mis),
      .kind     (br_kind),
      .priv     (br_priv),
      .hit      (hit)
   );

   if (DETAIL_W == ADDR_W) begin : g_det_full
      assign detail_ext = br_detail;
   end else begin : g_det_pad
      assign detail_ext = {{(ADDR_W-DETAIL_W){1'b0}}, br_detail};
   end

   assign payload = cfg_q.detail_sel ? detail_ext : br_target;

   brtrace_ring #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_ring (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (hit),
      .wr_src       (br_src),
      .wr_payload   (payload),
      .wr_is_detail (cfg_q.detail_sel),
      .rd_idx       (rd_idx),
      .rd_src       (rd_src),
      .rd_payload   (rd_payload),
      .rd_is_detail (rd_is_detail),
      .wr_ptr       (wr_ptr_o),
      .full         (full_o)
   );

   assign capture_o = hit;

endmodule

// File: rtl/brtrace_filter_chk.sv
module brtrace_filter_chk
   import brtrace_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int PTR_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             trace_en,
   input logic             br_valid,
   input logic [1:0]       br_kind,
   input logic [1:0]       br_priv,
   input logic             capture_o,
   input logic [PTR_W-1:0] wr_ptr_o,
   input logic             full_o,
   input brt_cfg_t         cfg
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] ptr_next;
   assign ptr_next = (wr_ptr_o == LAST) ? '0 : wr_ptr_o + 1'b1;

   assert_cap_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |-> (trace_en && br_valid));

   assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |=> (wr_ptr_o == $past(ptr_next)));

   assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_o |=> $stable(wr_ptr_o));

   assert_full_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |=> full_o);

   assert_full_on_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_o) |-> (wr_ptr_o == '0));

   assert_kind_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_o && !cfg.kind_any) |-> (cfg.kind_sel != 2'd0 && br_kind == cfg.kind_sel));

   assert_priv_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_o && cfg.plm != 4'h0) |-> cfg.plm[br_priv]);

endmodule

bind brtrace_filter brtrace_filter_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trace_en  (trace_en),
   .br_valid  (br_valid),
   .br_kind   (br_kind),
   .br_priv   (br_priv),
   .capture_o (capture_o),
   .wr_ptr_o  (wr_ptr_o),
   .full_o    (full_o),
   .cfg       (cfg_q)
);

// File: tb/brtrace_filter_bench.sv
module brtrace_filter_bench;
   import brtrace_pkg::*;

   localparam int DEPTH = 8;
   localparam int AW    = 32;
   localparam int DW    = 8;
   localparam int PW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trace_en = 1'b0;
   logic          cfg_we = 1'b0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic          br_valid = 1'b0, br_taken = 1'b0, br_tgt_mis = 1'b0, br_path_mis = 1'b0;
   logic [1:0]    br_kind = '0, br_priv = '0;
   logic [AW-1:0] br_src = '0, br_target = '0;
   logic [DW-1:0] br_detail = '0;
   logic          capture_o, full_o, rd_is_detail;
   logic [PW-1:0] wr_ptr_o;
   logic [PW-1:0] rd_idx = '0;
   logic [AW-1:0] rd_src, rd_payload;

   always #10 clk = ~clk;

   brtrace_filter #(.DEPTH(DEPTH), .ADDR_W(AW), .DETAIL_W(DW)) u_brtrace_filter (
      .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .br_valid(br_valid), .br_taken(br_taken), .br_tgt_mis(br_tgt_mis), .br_path_mis(br_path_mis),
      .br_kind(br_kind), .br_priv(br_priv), .br_src(br_src), .br_target(br_target),
      .br_detail(br_detail), .capture_o(capture_o), .wr_ptr_o(wr_ptr_o), .full_o(full_o),
      .rd_idx(rd_idx), .rd_src(rd_src), .rd_payload(rd_payload), .rd_is_detail(rd_is_detail)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // Bench-side model
   brt_cfg_t      m_cfg;
   logic [AW-1:0] m_src [DEPTH];
   logic [AW-1:0] m_pay [DEPTH];
   logic          m_det [DEPTH];
   int            m_ptr;
   bit            m_full;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit two_way(input logic [1:0] sel, input bit positive);
      case (sel)
         2'd0: return 0;
         2'd1: return !positive;
         2'd2: return positive;
         default: return 1;
      endcase
   endfunction

   // Returns tag of the first rejecting rule, or "" when accepted
   function automatic string reject_tag(input brt_cfg_t c, input bit en, v, tk, tm, pm,
                                        input logic [1:0] kd, pr);
      logic [3:0] mask;
      if (!en || !v) return "R9";
      if (!two_way(c.taken_sel, tk)) return "R2";
      if (!two_way(c.tgt_sel, !tm))  return "R3";
      if (!two_way(c.path_sel, !pm)) return "R4";
      if (!c.kind_any) begin
         if (c.kind_sel == 2'd0 || kd != c.kind_sel) return "R5";
      end
      mask = (c.plm == 4'h0) ? c.dflt_plm : c.plm;
      if (!mask[pr]) return "R7";
      return "";
   endfunction

   task automatic step(input bit we, input brt_cfg_t w, input bit en, v, tk, tm, pm,
                       input logic [1:0] kd, pr, input string tag);
      string rj;
      bit    exp;
      int    ri;
      @(negedge clk);
      cfg_we = we; cfg_wdata = w; trace_en = en; br_valid = v;
      br_taken = tk; br_tgt_mis = tm; br_path_mis = pm; br_kind = kd; br_priv = pr;
      br_src = $urandom; br_target = $urandom; br_detail = DW'($urandom);
      ri = $urandom_range(DEPTH-1);
      rd_idx = PW'(ri);
      #2;
      rj  = reject_tag(m_cfg, en, v, tk, tm, pm, kd, pr);
      exp = (rj == "");
      chk(capture_o == exp, (tag != "") ? tag : (exp ? "R10" : rj), "capture",
          capture_o, exp);
      chk(rd_src == m_src[ri] && rd_payload == m_pay[ri] && rd_is_detail == m_det[ri],
          "R8", "readback", rd_payload, m_pay[ri]);
      @(posedge clk);
      #1;
      if (exp) begin
         m_src[m_ptr] = br_src;
         m_pay[m_ptr] = m_cfg.detail_sel ? AW'(br_detail) : br_target;
         m_det[m_ptr] = m_cfg.detail_sel;
         if (m_ptr == DEPTH-1) begin m_ptr = 0; m_full = 1; end
         else m_ptr++;
      end
      if (we) m_cfg = w;
      chk(wr_ptr_o == PW'(m_ptr), "R11", "wr_ptr", wr_ptr_o, m_ptr);
      chk(full_o == m_full, "R11", "full", full_o, m_full);
   endtask

   function automatic brt_cfg_t all_pass();
      brt_cfg_t c = CFG_RESET;
      return c;
   endfunction

   initial begin
      brt_cfg_t c;
      void'($urandom(32'hB7C0_0451));
      m_cfg = CFG_RESET; m_ptr = 0; m_full = 0;
      for (int i = 0; i < DEPTH; i++) begin m_src[i] = '0; m_pay[i] = '0; m_det[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #2;
      chk(wr_ptr_o == '0, "R1", "reset wr_ptr", wr_ptr_o, 0);
      chk(full_o == 1'b0, "R1", "reset full", full_o, 0);
      chk(capture_o == 1'b0, "R1", "reset capture", capture_o, 0);

      // Reset config accepts anything once enabled
      step(0, all_pass(), 1, 1, 0, 1, 1, 2'd0, 2'd3, "R1");
      step(0, all_pass(), 0, 1, 1, 0, 0, 2'd1, 2'd0, "R9");
      step(0, all_pass(), 1, 0, 1, 0, 0, 2'd1, 2'd0, "R9");

      // Write same cycle as a branch: old config applies
      c = all_pass(); c.taken_sel = 2'd0;
      step(1, c, 1, 1, 1, 0, 0, 2'd2, 2'd1, "R12");
      step(0, c, 1, 1, 1, 0, 0, 2'd2, 2'd1, "R2");
      c.taken_sel = 2'd1;
      step(1, c, 1, 1, 0, 0, 0, 2'd2, 2'd1, "R2");
      step(0, c, 1, 1, 1, 0, 0, 2'd2, 2'd1, "R2");
      step(0, c, 1, 1, 0, 0, 0, 2'd2, 2'd1, "R2");

      // Target and path selectors
      c = all_pass(); c.tgt_sel = 2'd1;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R3");
      step(0, c, 1, 1, 1, 0, 0, 2'd0, 2'd0, "R3");
      step(0, c, 1, 1, 1, 1, 0, 2'd0, 2'd0, "R3");
      c = all_pass(); c.path_sel = 2'd2;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R4");
      step(0, c, 1, 1, 1, 0, 1, 2'd0, 2'd0, "R4");
      step(0, c, 1, 1, 1, 0, 0, 2'd0, 2'd0, "R4");

      // Privilege fallback mask
      c = all_pass(); c.plm = 4'h0; c.dflt_plm = 4'b0100;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R7");
      step(0, c, 1, 1, 1, 0, 0, 2'd1, 2'd2, "R7");
      step(0, c, 1, 1, 1, 0, 0, 2'd1, 2'd1, "R7");
      c.plm = 4'b0010;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R7");
      step(0, c, 1, 1, 1, 0, 0, 2'd1, 2'd1, "R7");
      step(0, c, 1, 1, 1, 0, 0, 2'd1, 2'd2, "R7");

      // Kind selector and bypass
      c = all_pass(); c.kind_any = 1'b0; c.kind_sel = 2'd2;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R6");
      step(0, c, 1, 1, 1, 0, 0, 2'd2, 2'd0, "R5");
      step(0, c, 1, 1, 1, 0, 0, 2'd1, 2'd0, "R5");
      step(0, c, 1, 1, 1, 0, 0, 2'd0, 2'd0, "R6");
      c.kind_sel = 2'd0;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R5");
      step(0, c, 1, 1, 1, 0, 0, 2'd2, 2'd0, "R5");

      // Detail payload
      c = all_pass(); c.detail_sel = 1'b1;
      step(1, c, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R8");
      step(0, c, 1, 1, 1, 0, 0, 2'd3, 2'd0, "R8");

      // Random traffic, selectors biased toward accepting
      for (int n = 0; n < 800; n++) begin
         bit we;
         we = ($urandom_range(7) == 0);
         c = brt_cfg_t'(CFG_W'($urandom));
         if ($urandom_range(1)) c.taken_sel = 2'd3;
         if ($urandom_range(1)) c.tgt_sel   = 2'd3;
         if ($urandom_range(1)) c.path_sel  = 2'd3;
         if ($urandom_range(1)) c.kind_any  = 1'b1;
         step(we, c, $urandom_range(7) != 0, $urandom_range(5) != 0,
              1'($urandom), 1'($urandom), 1'($urandom),
              2'($urandom), 2'($urandom), "");
      end

      // Full readback of every slot
      @(negedge clk); br_valid = 0; cfg_we = 0;
      for (int i = 0; i < DEPTH; i++) begin
         rd_idx = PW'(i);
         #2;
         chk(rd_src == m_src[i], "R10", "slot src", rd_src, m_src[i]);
         chk(rd_payload == m_pay[i], "R8", "slot payload", rd_payload, m_pay[i]);
         chk(rd_is_detail == m_det[i], "R8", "slot detail flag", rd_is_detail, m_det[i]);
      end

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule